// File: doc/BRIEF.md
# Tagged Register Status and Value Table

This block stores the architectural register values of an out-of-order core, together with a per-register record of which in-flight instruction will produce each register's next value. At issue time the front end names a destination register and supplies the tag it has allocated to the issuing instruction. The table then records that the register waits on that tag. In the same cycle, two source lookups return, for each operand, either a usable value or the tag the operand must wait for.

Results come back on a single result broadcast bus, which carries a value and the tag of its producer. Each register takes the broadcast value only if the broadcast tag equals the tag it is currently waiting on. A register that has since been renamed to a younger producer discards the older result. Out-of-order completion of two writers to one register therefore never leaves the older value in place, and issue never has to stall. Tag 0 is reserved to mean "no producer pending".

Top module: `tag_status_table`

## Requirements
- R1: After reset, every register holds value 0 with no pending producer, and a lookup of any register returns ready=1, value 0 and tag 0.
- R2: An issue (`iss_valid`=1) to register d with tag t makes later lookups of d return ready=1 only once a matching result arrives. Until then they return ready=0 with tag t.
- R3: A second issue to the same destination replaces the pending tag with the newer tag, and later lookups report the newer tag.
- R4: A broadcast whose tag differs from a register's pending tag leaves that register's value and pending tag unchanged.
- R5: A broadcast whose tag equals a register's non-zero pending tag loads the broadcast value into that register and clears its pending tag to 0.
- R6: A lookup made in the same cycle as an issue to the same register reports the register's state from before that issue. The older value or tag therefore stays visible to the issuing instruction.
- R7: The lookup format is as follows. With no pending tag, a lookup gives ready=1, the stored value and tag 0. With a pending tag, it gives ready=0, value 0 and the pending tag.
- R8: When an issue and a broadcast address the same register in one cycle, the issue's tag becomes the pending tag. The broadcast value is written only if its tag matched the tag pending before that cycle.
- R9: A lookup of a register whose pending tag equals the tag of a broadcast in the same cycle returns ready=1 with the broadcast value and tag 0.
- R10: A broadcast with tag 0 never changes any register, and tag 0 is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 3 | Destination register of the issuing instruction |
| iss_tag | input | 4 | Tag allocated to the issuing instruction (non-zero) |
| cdb_valid | input | 1 | A result is broadcast this cycle |
| cdb_tag | input | 4 | Tag of the producer of the broadcast result |
| cdb_data | input | 16 | Broadcast result value |
| src_a_idx | input | 3 | Register looked up for operand A |
| src_a_ready | output | 1 | Operand A value is usable |
| src_a_value | output | 16 | Operand A value when ready, else 0 |
| src_a_tag | output | 4 | Producer tag for operand A when not ready, else 0 |
| src_b_idx | input | 3 | Register looked up for operand B |
| src_b_ready | output | 1 | Operand B value is usable |
| src_b_value | output | 16 | Operand B value when ready, else 0 |
| src_b_tag | output | 4 | Producer tag for operand B when not ready, else 0 |

## Verification
The assertions assume that the issue port never presents tag 0 with `iss_valid` high. They also assume that inputs stay idle while reset is held. The stimulus draws issue tags only from 1 to 15 and drives every input to zero until a few cycles after reset is released. Broadcast tags, in contrast, sweep all sixteen codes, including 0. This exercises the stale-result and reserved-tag paths on both busy and idle registers.

// File: rtl/tst_pkg.sv
package tst_pkg;
  localparam int unsigned NUM_REGS_DEF = 8;
  localparam int unsigned TAG_W_DEF    = 4;
  localparam int unsigned DATA_W_DEF   = 16;
  localparam int unsigned NUM_SRC      = 2;

  // Tag value reserved for "nothing pending".
  function automatic bit tag_is_idle(input logic [TAG_W_DEF-1:0] t);
    return (t == '0);
  endfunction
endpackage

// File: rtl/tst_reset_sync.sv
module tst_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tst_entry.sv
module tst_entry #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_hit,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [DATA_W-1:0] value_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [DATA_W-1:0] value_q, value_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              cdb_match, value_en, tag_en;

  // Next-state logic
  always_comb begin
    cdb_match = cdb_valid && (tag_q != '0) && (cdb_tag == tag_q);
    value_en  = cdb_match;
    tag_en    = iss_hit || cdb_match;
    value_d   = cdb_data;
    tag_d     = iss_hit ? iss_tag : '0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      tag_q   <= '0;
    end else begin
      if (value_en) value_q <= value_d;
      if (tag_en)   tag_q   <= tag_d;
    end
  end

  assign value_o = value_q;
  assign tag_o   = tag_q;

  // Input assumption: reserved tag is never issued (R10)
  a_r10_no_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    iss_hit |-> (iss_tag != '0));

  a_r2_issue_records_tag: assert property (@(posedge clk) disable iff (!rst_n)
    iss_hit |=> (tag_o == $past(iss_tag)));

  a_r4_stale_result_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (cdb_tag != tag_o)) |=> (value_o == $past(value_o)));

  a_r5_match_loads_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (tag_o != '0) && (cdb_tag == tag_o)) |=> (value_o == $past(cdb_data)));

  a_r5_match_clears_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (tag_o != '0) && (cdb_tag == tag_o) && !iss_hit) |=> (tag_o == '0));

  a_r10_idle_broadcast_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (cdb_tag == '0)) |=> $stable(value_o));
endmodule

// File: rtl/tst_read_port.sv
module tst_read_port #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] values,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            cdb_valid,
  input  logic [TAG_W-1:0]                cdb_tag,
  input  logic [DATA_W-1:0]               cdb_data,
  output logic                            ready,
  output logic [DATA_W-1:0]               value,
  output logic [TAG_W-1:0]                tag
);
  logic [DATA_W-1:0] sel_value;
  logic [TAG_W-1:0]  sel_tag;
  logic              bypass;

  always_comb begin
    sel_value = values[idx];
    sel_tag   = tags[idx];
    bypass    = cdb_valid && (sel_tag != '0) && (cdb_tag == sel_tag);
    if (sel_tag == '0) begin
      ready = 1'b1;
      value = sel_value;
      tag   = '0;
    end else if (bypass) begin
      ready = 1'b1;
      value = cdb_data;
      tag   = '0;
    end else begin
      ready = 1'b0;
      value = '0;
      tag   = sel_tag;
    end
  end
endmodule

// File: rtl/tag_status_table.sv
module tag_status_table #(
  parameter int unsigned NUM_REGS = tst_pkg::NUM_REGS_DEF,
  parameter int unsigned TAG_W    = tst_pkg::TAG_W_DEF,
  parameter int unsigned DATA_W   = tst_pkg::DATA_W_DEF,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic [IDX_W-1:0]  src_a_idx,
  output logic              src_a_ready,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_a_tag,
  input  logic [IDX_W-1:0]  src_b_idx,
  output logic              src_b_ready,
  output logic [DATA_W-1:0] src_b_value,
  output logic [TAG_W-1:0]  src_b_tag
);
  localparam int unsigned NSRC = tst_pkg::NUM_SRC;

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_values;
  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tags;
  logic [NSRC-1:0][IDX_W-1:0]      src_idx;
  logic [NSRC-1:0]                 src_ready;
  logic [NSRC-1:0][DATA_W-1:0]     src_value;
  logic [NSRC-1:0][TAG_W-1:0]      src_tag;

  tst_reset_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = iss_valid && (iss_dst == IDX_W'(r));
    tst_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .iss_hit   (hit),
      .iss_tag   (iss_tag),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_data  (cdb_data),
      .value_o   (reg_values[r]),
      .tag_o     (reg_tags[r])
    );
  end

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    tst_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_port (
      .values    (reg_values),
      .tags      (reg_tags),
      .idx       (src_idx[s]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_data  (cdb_data),
      .ready     (src_ready[s]),
      .value     (src_value[s]),
      .tag       (src_tag[s])
    );
  end

  assign src_a_ready = src_ready[0];
  assign src_a_value = src_value[0];
  assign src_a_tag   = src_tag[0];
  assign src_b_ready = src_ready[1];
  assign src_b_value = src_value[1];
  assign src_b_tag   = src_tag[1];

  // R2: an issued destination is not ready in the following cycle unless its result arrives then
  a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_valid && (src_a_idx == iss_dst)) ##1 (!cdb_valid && (src_a_idx == $past(iss_dst)))
      |-> !src_a_ready);

  // R7: operand A never reports both ready and a pending tag
  a_r7_ready_excludes_tag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_a_ready |-> (src_a_tag == '0));
endmodule

// File: tb/tag_status_table_test.sv
module tag_status_table_test;
  localparam int NR = 8;
  localparam int TW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [2:0]    iss_dst = '0;
  logic [TW-1:0] iss_tag = '0;
  logic          cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic [2:0]    src_a_idx = '0, src_b_idx = '0;
  logic          src_a_ready, src_b_ready;
  logic [DW-1:0] src_a_value, src_b_value;
  logic [TW-1:0] src_a_tag, src_b_tag;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m_val [NR];
  logic [TW-1:0] m_tag [NR];

  always #2.5 clk = ~clk;

  tag_status_table uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
    .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag)
  );

  task automatic check_port(input string lbl, input int k, input logic rdy,
                            input logic [DW-1:0] v, input logic [TW-1:0] t);
    logic          e_rdy;
    logic [DW-1:0] e_v;
    logic [TW-1:0] e_t;
    if (m_tag[k] == '0) begin
      e_rdy = 1'b1; e_v = m_val[k]; e_t = '0;
    end else if (cdb_valid && cdb_tag == m_tag[k]) begin
      e_rdy = 1'b1; e_v = cdb_data; e_t = '0;
    end else begin
      e_rdy = 1'b0; e_v = '0; e_t = m_tag[k];
    end
    total++;
    if (rdy !== e_rdy || v !== e_v || t !== e_t) begin
      bad++;
      $display("FAIL %s reg%0d: got rdy=%0b val=%h tag=%0d exp rdy=%0b val=%h tag=%0d",
               lbl, k, rdy, v, t, e_rdy, e_v, e_t);
    end
  endtask

  // One cycle: drive at falling edge, check before rising edge, update model after it.
  task automatic cyc(input string lbl, input logic iv, input int id, input int it,
                     input logic cv, input int ct, input logic [DW-1:0] cd,
                     input int sa, input int sb);
    @(negedge clk);
    iss_valid = iv; iss_dst = 3'(id); iss_tag = TW'(it);
    cdb_valid = cv; cdb_tag = TW'(ct); cdb_data = cd;
    src_a_idx = 3'(sa); src_b_idx = 3'(sb);
    #1;
    check_port(lbl, sa, src_a_ready, src_a_value, src_a_tag);
    check_port(lbl, sb, src_b_ready, src_b_value, src_b_tag);
    @(posedge clk);
    for (int k = 0; k < NR; k++) begin
      logic m;
      m = cv && (m_tag[k] != '0) && (TW'(ct) == m_tag[k]);
      if (m) m_val[k] = cd;
      if (iv && id == k) m_tag[k] = TW'(it);
      else if (m)        m_tag[k] = '0;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) begin m_val[k] = '0; m_tag[k] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R7: reset state, every register through both ports
    for (int k = 0; k < NR; k++)
      cyc("R1 reset", 1'b0, 0, 0, 1'b0, 0, '0, k, NR - 1 - k);

    for (int r = 0; r < NR; r++) begin
      for (int t = 1; t < 16; t++) begin
        int t2;
        t2 = (t % 15) + 1;
        // R2 / R6: issue to r while port A reads r (sees pre-issue state)
        cyc("R2 R6 issue", 1'b1, r, t, 1'b0, 0, '0, r, (r + 1) % NR);
        // R3 / R8: reissue with t2 while the old tag t broadcasts (value lands, t2 pending)
        cyc("R3 R8 reissue", 1'b1, r, t2, 1'b1, t, DW'(16'h8000 + r * 256 + t * 16), r, (r + 3) % NR);
        // R4 R5 R9 R10: sweep every broadcast tag, incl. 0 and stale ones
        for (int c = 0; c < 16; c++)
          cyc("R4 R5 R9 R10 sweep", 1'b0, 0, 0, 1'b1, c, DW'(r * 4096 + t * 256 + c * 16 + 1),
              r, (r + c) % NR);
        // R7: idle readback after the sweep
        cyc("R5 R7 readback", 1'b0, 0, 0, 1'b0, 0, '0, r, (r + 5) % NR);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule